// File: doc/BRIEF.md
# Visual Reaction Test Sequencer

This block runs a reaction test on one seven-segment display. A rising edge on the start input launches a run. The block then presents thirty decimal digits in a fixed order, one after another, and lights each one on an active-low segment output. The digits come from a stimulus table inside the block. Each non-target digit stays on for a parameterised number of milliseconds. When the target digit 7 appears, the block counts whole milliseconds until the response input rises. It adds that latency to a running sum, counts the target, and moves at once to the next digit. If no response arrives before a timeout, the timeout value is recorded instead.

The millisecond tick comes from a divider on the system clock. The divider restarts each time a new digit appears, so every latency is measured from the exact cycle the digit became visible. When the last digit ends, the block pulses a completion flag for one cycle. The latency sum and the number of targets are then valid for a downstream averaging stage, and they hold until the next run starts. Button debouncing is left to the surrounding logic.

Top module: `rt_reaction`

## Requirements
- R1: After reset the segment output is 7'h7F (all segments off), the sum and count are 0 and done is 0. While idle the display stays blank and the response input has no effect.
- R2: A rising edge on start while idle makes entry 0 visible in the next cycle and clears the sum and count. A start edge during a run has no effect on the sequence.
- R3: The thirty entries are presented in this order: 3,1,7,4,9,7,2,5,8,7,0,6,7,3,1,4,7,9,2,7,5,8,0,7,6,1,3,9,4,2. The first entry is not 7, and the table holds seven 7s.
- R4: The segment output is active-low with bit 0 = segment a through bit 6 = segment g. Digits 0..9 are shown as 40,79,24,30,19,12,02,78,00,10 (hex).
- R5: A non-7 entry stays visible for exactly HOLD_MS*CLKS_PER_MS cycles. Response edges while it is shown are ignored.
- R6: If the response rises in cycle c of a 7 entry (cycle 0 being its first visible cycle), the latency added is floor(c/CLKS_PER_MS). The count rises by one and the next entry is visible from cycle c+1.
- R7: If no response edge arrives, a 7 entry ends after TIMEOUT_MS*CLKS_PER_MS cycles and adds TIMEOUT_MS. An edge in its final cycle wins and adds TIMEOUT_MS-1.
- R8: The response input is edge-detected. A level already high when a 7 appears, and held, counts as no response.
- R9: In the cycle after the last entry ends, done is high for exactly one cycle, the display is blank, and the sum and count hold the run totals. They stay unchanged while idle.
- R10: Reset in the middle of a run returns the block to idle, with the display blank and the sum and count cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a run on a rising edge while idle |
| resp | input | 1 | Response button, rising edge ends a latency measurement |
| seg | output | 7 | Active-low segment pattern, bit 0 = a, bit 6 = g |
| lat_sum | output | SUM_W | Sum of recorded latencies in milliseconds |
| tgt_count | output | CNT_W | Number of target entries presented |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench presses on the very first cycle of a 7 and on the last cycle before the timeout tick, and it lets other 7s expire. A divider that is not realigned, or an off-by-one compare, would shift these latencies by one millisecond or change how long each digit stays on. One 7 appears with the button already held down. A level-sensitive design would record zero there instead of the timeout. Presses and a start edge land in the middle of non-target digits; a design that reacted to them would cut a digit short or restart the run. A reset in the middle of a run, after a timeout has already been added, must clear the sum and count that the bench has just seen as nonzero.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int SEQ_LEN = 30;
    localparam int IDX_W   = $clog2(SEQ_LEN);
    localparam logic [3:0] TARGET_DIGIT = 4'd7;
    localparam logic [6:0] SEG_BLANK    = 7'h7F;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHOW,
        ST_DONE
    } rt_state_e;

    typedef struct packed {
        logic [3:0] digit;
        logic       is_target;
    } rt_entry_t;

    // stimulus table; entry 0 is deliberately not the target
    function automatic logic [3:0] stim_digit(input logic [IDX_W-1:0] idx);
        logic [3:0] d;
        case (idx)
            5'd0:  d = 4'd3;  5'd1:  d = 4'd1;  5'd2:  d = 4'd7;
            5'd3:  d = 4'd4;  5'd4:  d = 4'd9;  5'd5:  d = 4'd7;
            5'd6:  d = 4'd2;  5'd7:  d = 4'd5;  5'd8:  d = 4'd8;
            5'd9:  d = 4'd7;  5'd10: d = 4'd0;  5'd11: d = 4'd6;
            5'd12: d = 4'd7;  5'd13: d = 4'd3;  5'd14: d = 4'd1;
            5'd15: d = 4'd4;  5'd16: d = 4'd7;  5'd17: d = 4'd9;
            5'd18: d = 4'd2;  5'd19: d = 4'd7;  5'd20: d = 4'd5;
            5'd21: d = 4'd8;  5'd22: d = 4'd0;  5'd23: d = 4'd7;
            5'd24: d = 4'd6;  5'd25: d = 4'd1;  5'd26: d = 4'd3;
            5'd27: d = 4'd9;  5'd28: d = 4'd4;  5'd29: d = 4'd2;
            default: d = 4'd0;
        endcase
        return d;
    endfunction

    // active-low, bit 0 = segment a ... bit 6 = segment g
    function automatic logic [6:0] seg_low(input logic [3:0] d);
        logic [6:0] s;
        case (d)
            4'd0: s = 7'h40; 4'd1: s = 7'h79; 4'd2: s = 7'h24;
            4'd3: s = 7'h30; 4'd4: s = 7'h19; 4'd5: s = 7'h12;
            4'd6: s = 7'h02; 4'd7: s = 7'h78; 4'd8: s = 7'h00;
            4'd9: s = 7'h10;
            default: s = SEG_BLANK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rt_ms_tick.sv
module rt_ms_tick #(
    parameter int CLKS_PER_MS = 125000,
    localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(CLKS_PER_MS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rt_stim_rom.sv
module rt_stim_rom
    import rt_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output rt_entry_t        entry
);
    always_comb begin
        entry.digit     = stim_digit(idx);
        entry.is_target = (entry.digit == TARGET_DIGIT);
    end
endmodule

// File: rtl/rt_lat_accum.sv
module rt_lat_accum #(
    parameter int LAT_W = 10,
    parameter int SUM_W = 15,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add,
    input  logic [LAT_W-1:0] lat,
    output logic [SUM_W-1:0] sum,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
            cnt <= '0;
        end else if (add) begin
            sum <= sum + SUM_W'(lat);
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rt_reaction.sv
module rt_reaction
    import rt_pkg::*;
#(
    parameter int CLKS_PER_MS = 125000,
    parameter int HOLD_MS     = 1000,
    parameter int TIMEOUT_MS  = 1000,
    localparam int MS_MAX = (HOLD_MS > TIMEOUT_MS) ? HOLD_MS : TIMEOUT_MS,
    localparam int MS_W   = $clog2(MS_MAX + 1),
    localparam int SUM_W  = $clog2(SEQ_LEN * TIMEOUT_MS + 1),
    localparam int CNT_W  = $clog2(SEQ_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             resp,
    output logic [6:0]       seg,
    output logic [SUM_W-1:0] lat_sum,
    output logic [CNT_W-1:0] tgt_count,
    output logic             done
);
    rt_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [MS_W-1:0]  ms_cnt;
    logic             start_q, resp_q;
    rt_entry_t        entry;
    logic             tick, launch, adv, add, hold_end, tmo_end, start_rise, resp_rise;
    logic [MS_W-1:0]  lat;

    assign start_rise = start & ~start_q;
    assign resp_rise  = resp & ~resp_q;
    assign launch     = (state == ST_IDLE) && start_rise;
    assign hold_end   = tick && (ms_cnt == MS_W'(HOLD_MS - 1));
    assign tmo_end    = tick && (ms_cnt == MS_W'(TIMEOUT_MS - 1));

    always_comb begin
        adv = 1'b0;
        if (state == ST_SHOW)
            adv = entry.is_target ? (resp_rise || tmo_end) : hold_end;
        add = adv && entry.is_target;
        lat = resp_rise ? ms_cnt : MS_W'(TIMEOUT_MS);
    end

    rt_stim_rom u_rom (.idx(idx), .entry(entry));

    rt_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk(clk), .rst(rst), .clr(launch || adv), .tick(tick)
    );

    rt_lat_accum #(.LAT_W(MS_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_acc (
        .clk(clk), .rst(rst), .clr(launch), .add(add), .lat(lat),
        .sum(lat_sum), .cnt(tgt_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            ms_cnt  <= '0;
            start_q <= 1'b0;
            resp_q  <= 1'b0;
        end else begin
            start_q <= start;
            resp_q  <= resp;
            case (state)
                ST_IDLE: if (start_rise) begin
                    state  <= ST_SHOW;
                    idx    <= '0;
                    ms_cnt <= '0;
                end
                ST_SHOW: if (adv) begin
                    ms_cnt <= '0;
                    if (idx == IDX_W'(SEQ_LEN - 1)) state <= ST_DONE;
                    else                            idx   <= idx + 1'b1;
                end else if (tick) begin
                    ms_cnt <= ms_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign seg  = (state == ST_SHOW) ? seg_low(entry.digit) : SEG_BLANK;
    assign done = (state == ST_DONE);
endmodule

// File: rtl/rt_reaction_chk.sv
module rt_reaction_chk #(
    parameter int TIMEOUT_MS = 1000,
    parameter int SUM_W      = 15,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [6:0]       seg,
    input logic [SUM_W-1:0] lat_sum,
    input logic [CNT_W-1:0] tgt_count,
    input logic             done
);
    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: display is dark while the totals are presented
    a_r9_blank_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (seg == 7'h7F));

    // R6: the target count only steps by one or clears
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        (tgt_count != $past(tgt_count)) |->
            ((tgt_count == $past(tgt_count) + CNT_W'(1)) || (tgt_count == '0)));

    // R6: a nonzero sum only grows together with the count
    a_r6_sum_with_count: assert property (@(posedge clk) disable iff (rst)
        ((lat_sum != $past(lat_sum)) && (lat_sum != '0)) |->
            (tgt_count == $past(tgt_count) + CNT_W'(1)));

    // R7: no single latency exceeds the timeout
    a_r7_latency_cap: assert property (@(posedge clk) disable iff (rst)
        ((tgt_count == $past(tgt_count) + CNT_W'(1)) && (tgt_count != '0)) |->
            ((lat_sum - $past(lat_sum)) <= SUM_W'(TIMEOUT_MS)));
endmodule

bind rt_reaction rt_reaction_chk #(
    .TIMEOUT_MS(TIMEOUT_MS), .SUM_W(SUM_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .seg(seg), .lat_sum(lat_sum),
    .tgt_count(tgt_count), .done(done)
);

// File: tb/rt_reaction_test.sv
module rt_reaction_test;
    localparam int P = 4;
    localparam int H = 5;
    localparam int T = 8;
    localparam int SW = $clog2(30 * T + 1);
    localparam int CW = $clog2(31);

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, resp = 1'b0;
    logic [6:0] seg;
    logic [SW-1:0] lat_sum;
    logic [CW-1:0] tgt_count;
    logic done;

    int checks = 0, fails = 0, cyc = 0;
    int seq[30] = '{3,1,7,4,9,7,2,5,8,7,0,6,7,3,1,4,7,9,2,7,5,8,0,7,6,1,3,9,4,2};

    rt_reaction #(.CLKS_PER_MS(P), .HOLD_MS(H), .TIMEOUT_MS(T)) uut (
        .clk(clk), .rst(rst), .start(start), .resp(resp),
        .seg(seg), .lat_sum(lat_sum), .tgt_count(tgt_count), .done(done)
    );

    always #4 clk = ~clk;

    function automatic logic [6:0] enc(input int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
            8: return 7'h00; 9: return 7'h10; default: return 7'h7F;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // R1: reset state and idle insensitivity to the response input
    task automatic test_reset_idle();
        check("R1 seg", seg, 7'h7F);
        check("R1 sum", lat_sum, 0);
        check("R1 count", tgt_count, 0);
        check("R1 done", done, 0);
        resp = 1'b1; @(negedge clk); resp = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle resp ignored", seg, 7'h7F);
    endtask

    // launches a run and walks all 30 entries; acts: >=0 press cycle, -1 none, -2 held
    task automatic run_seq(input int acts[7], input bit poke, input int exp_sum);
        int k = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R2 sum cleared", lat_sum, 0);
        check("R2 count cleared", tgt_count, 0);
        for (int i = 0; i < 30; i++) begin
            check($sformatf("R3 R4 entry %0d", i), seg, enc(seq[i]));
            if (seq[i] == 7) begin
                int a = acts[k];
                k++;
                if (a >= 0) begin
                    repeat (a) @(negedge clk);
                    check("R6 still shown", seg, 7'h78);
                    resp = 1'b1;
                    @(negedge clk);
                    resp = 1'b0;
                end else begin
                    repeat (T * P - 1) @(negedge clk);
                    check("R7 R8 still shown before timeout", seg, 7'h78);
                    @(negedge clk);
                    resp = 1'b0;
                end
            end else if (poke) begin
                bit hold_next = (i < 29) && (seq[i+1] == 7) && (acts[k] == -2);
                repeat (2) @(negedge clk);
                resp = 1'b1;
                if (i == 10) start = 1'b1;
                @(negedge clk);
                resp = hold_next;
                start = 1'b0;
                repeat (H * P - 4) @(negedge clk);
                check("R5 R2 held despite presses", seg, enc(seq[i]));
                @(negedge clk);
            end else begin
                repeat (H * P - 1) @(negedge clk);
                check("R5 held full time", seg, enc(seq[i]));
                @(negedge clk);
            end
        end
        check("R9 done", done, 1);
        check("R9 blank", seg, 7'h7F);
        check("R9 R6 R7 sum", lat_sum, exp_sum);
        check("R9 count", tgt_count, 7);
        @(negedge clk);
        check("R9 done one cycle", done, 0);
        resp = 1'b1; @(negedge clk); resp = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 sum held", lat_sum, exp_sum);
        check("R1 idle blank", seg, 7'h7F);
    endtask

    // R10: reset in the middle of a run after one timeout
    task automatic test_mid_reset();
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (95) @(negedge clk);
        check("R10 pre entry", seg, enc(9));
        check("R10 pre count", tgt_count, 1);
        check("R10 pre sum", lat_sum, T);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R10 seg", seg, 7'h7F);
        check("R10 sum", lat_sum, 0);
        check("R10 count", tgt_count, 0);
        check("R10 done", done, 0);
        repeat (5) @(negedge clk);
        check("R10 stays idle", seg, 7'h7F);
    endtask

    initial begin
        do_reset();
        test_reset_idle();
        // presses at first cycle and at the last cycle before timeout
        run_seq('{0, 3, 4, 13, 31, 7, 22}, 1'b0, 17);
        // timeouts, held button, stray presses and start mid-run
        run_seq('{10, -1, -2, 0, -1, 31, -2}, 1'b1, 41);
        test_mid_reset();
        summary();
        $finish;
    end
endmodule